// File: doc/BRIEF.md
# Destination Address Hash Filter

This block decides whether a received Ethernet frame is kept, based only on its 48-bit destination address. Software loads a station address and two 64-bit hash tables through a small register write port. One table is for individual (unicast) addresses and the other is for group (multicast) addresses. A one-cycle start strobe presents an address. The block then runs a reflected CRC-32 over the six address bytes, one bit per clock. It takes the top six bits of the result as a table index and raises a done pulse together with the accept verdict.

An address that equals the programmed station address is accepted without using the hash, and the all-ones broadcast address is always accepted. For any other address, the group bit (bit 0 of the first byte) selects a table, and the table bit at the hash index gives the verdict. Each table is spread over two 32-bit registers, a lower and an upper word. A combinational read port returns the register contents, and the unused lower half of the second station register reads back as a fixed marker.

Top module: `dst_addr_filter`

## Requirements
- R1: After reset, `done` and `accept` are 0 and every register reads 0, except the second station register, which reads 0x00008808.
- R2: The hash is a CRC-32 with an all-ones start value. It is fed byte 0 (`addr_in[47:40]`) through byte 5 (`addr_in[7:0]`), and each byte least significant bit first. On each bit the CRC shifts right by one, then is XORed with 0xEDB88320 when the incoming bit differs from the CRC's bit 0 before the shift.
- R3: The table index is the final CRC bits 31:26. An index of 32 or more selects bit (index-32) of the table's upper word, and a smaller index selects bit index of its lower word. For an address that is neither the station address nor broadcast, `accept` equals that table bit.
- R4: Bit 0 of byte 0 (`addr_in[40]`) chooses the table. A 0 uses the individual table (select 2 lower word, select 3 upper word). A 1 uses the group table (select 4 lower word, select 5 upper word).
- R5: An address equal to the station address is accepted whatever the tables hold. Select 0 holds bytes 0..3 with byte 0 in bits 31:24. Select 1 bits 31:16 hold bytes 4 and 5, with byte 4 in bits 31:24.
- R6: The address 0xFFFFFFFFFFFF is always accepted.
- R7: With both group words at zero, every group address other than broadcast and the station address is rejected, whatever the individual table holds.
- R8: `done` is high for exactly one cycle, on the cycle after the 48th rising edge that follows the edge that sampled `start`. `accept` is valid with `done` and holds until the next `done`.
- R9: A `start` that arrives while a hash is in progress is ignored: it produces no extra `done` and does not change the result of the hash in progress.
- R10: The read port returns the register chosen by `rd_sel` (encodings 0..5 as above). Bits 15:0 of select 1 always read 0x8808 whatever was written there, and selects 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Register select for the read |
| rd_data | output | 32 | Read data (combinational) |
| start | input | 1 | Sample `addr_in` and begin hashing |
| addr_in | input | 48 | Destination address, byte 0 in bits 47:40 |
| done | output | 1 | One-cycle verdict strobe |
| accept | output | 1 | Verdict: 1 keeps the frame |

## Verification
The bench sweeps several unicast addresses and, for each one, sets a table bit at the hash index computed by its own model, then sets the neighbouring bit instead. A wrong byte order, bit order, polynomial or index slice would accept the neighbour or reject the computed bit. It checks that indices land in both the upper and lower table words, so a design that swaps the two words rejects the expected bit. Group addresses are run with only the individual table filled, and unicast addresses with only the group table filled, which catches a table chosen from the wrong bit. The monitor pins `done` to its exact cycle and fails on any stray `done`, which exposes an off-by-one hash length and a restart triggered by a second `start` mid-hash.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;

   // register select encodings shared by write and read ports
   typedef enum logic [2:0] {
      SEL_STN_HEAD = 3'd0,
      SEL_STN_TAIL = 3'd1,
      SEL_IND_LO   = 3'd2,
      SEL_IND_HI   = 3'd3,
      SEL_GRP_LO   = 3'd4,
      SEL_GRP_HI   = 3'd5
   } dafilt_sel_e;

   localparam int unsigned TBL_WORDS = 4;
   localparam logic [15:0] STN_MARKER = 16'h8808;

endpackage

// File: rtl/dafilt_regfile.sv
module dafilt_regfile
   import dafilt_pkg::*;
#(
   parameter int unsigned REG_W  = 32,
   parameter int unsigned SEL_W  = 3,
   parameter int unsigned ADDR_W = 48
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [SEL_W-1:0]     wr_sel,
   input  logic [REG_W-1:0]     wr_data,
   input  logic [SEL_W-1:0]     rd_sel,
   output logic [REG_W-1:0]     rd_data,
   output logic [ADDR_W-1:0]    station,
   output logic [2*REG_W-1:0]   ind_tbl,
   output logic [2*REG_W-1:0]   grp_tbl
);
   localparam int unsigned HALF = REG_W / 2;

   logic [REG_W-1:0]                 stn_head_q;
   logic [HALF-1:0]                  stn_tail_q;
   logic [TBL_WORDS-1:0][REG_W-1:0]  tbl_q;
   logic [TBL_WORDS-1:0]             tbl_wen;

   // per-word write enables for the four table words (selects 2..5)
   for (genvar w = 0; w < TBL_WORDS; w++) begin : g_tbl_wen
      assign tbl_wen[w] = wr_en && (wr_sel == SEL_W'(int'(SEL_IND_LO) + w));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stn_head_q <= '0;
         stn_tail_q <= '0;
         tbl_q      <= '0;
      end else begin
         if (wr_en && wr_sel == SEL_W'(SEL_STN_HEAD)) stn_head_q <= wr_data;
         if (wr_en && wr_sel == SEL_W'(SEL_STN_TAIL)) stn_tail_q <= wr_data[REG_W-1:HALF];
         for (int w = 0; w < TBL_WORDS; w++) begin
            if (tbl_wen[w]) tbl_q[w] <= wr_data;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_sel)
         SEL_W'(SEL_STN_HEAD): rd_data = stn_head_q;
         SEL_W'(SEL_STN_TAIL): rd_data = {stn_tail_q, HALF'(STN_MARKER)};
         SEL_W'(SEL_IND_LO):   rd_data = tbl_q[0];
         SEL_W'(SEL_IND_HI):   rd_data = tbl_q[1];
         SEL_W'(SEL_GRP_LO):   rd_data = tbl_q[2];
         SEL_W'(SEL_GRP_HI):   rd_data = tbl_q[3];
         default:              rd_data = '0;
      endcase
   end

   assign station = {stn_head_q, stn_tail_q};
   assign ind_tbl = {tbl_q[1], tbl_q[0]};
   assign grp_tbl = {tbl_q[3], tbl_q[2]};

   // R10: table contents only move on a write strobe
   p_tbl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(ind_tbl) && $stable(grp_tbl) && $stable(station));

   // R5: a write to the station head lands in the head, others leave it alone
   p_head_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel != SEL_W'(SEL_STN_HEAD)) |=> $stable(stn_head_q));

endmodule

// File: rtl/dafilt_crc_engine.sv
module dafilt_crc_engine #(
   parameter int unsigned  ADDR_BYTES = 6,
   parameter int unsigned  CRC_W      = 32,
   parameter int unsigned  HASH_BITS  = 6,
   parameter logic [31:0]  CRC_POLY   = 32'hEDB88320
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic [8*ADDR_BYTES-1:0]       addr,
   output logic                          busy,
   output logic                          last,
   output logic [HASH_BITS-1:0]          idx_next,
   output logic [8*ADDR_BYTES-1:0]       addr_held
);
   localparam int unsigned ADDR_W = 8 * ADDR_BYTES;
   localparam int unsigned CNT_W  = $clog2(ADDR_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_W - 1);

   logic [ADDR_W-1:0] ser_vec;
   logic [ADDR_W-1:0] shreg_q;
   logic [CRC_W-1:0]  crc_q;
   logic [CRC_W-1:0]  crc_nxt;
   logic [CNT_W-1:0]  cnt_q;
   logic              fb;

   // serial order: byte 0 first (top of the address), each byte LSB first
   for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_byte
      for (genvar j = 0; j < 8; j++) begin : g_bit
         assign ser_vec[8*b + j] = addr[ADDR_W - 8 - 8*b + j];
      end
   end

   assign fb       = shreg_q[0] ^ crc_q[0];
   assign crc_nxt  = (crc_q >> 1) ^ (fb ? CRC_POLY[CRC_W-1:0] : '0);
   assign last     = busy && (cnt_q == CNT_LAST);
   assign idx_next = crc_nxt[CRC_W-1 -: HASH_BITS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         cnt_q     <= '0;
         shreg_q   <= '0;
         crc_q     <= '0;
         addr_held <= '0;
      end else if (start && !busy) begin
         busy      <= 1'b1;
         cnt_q     <= '0;
         shreg_q   <= ser_vec;
         crc_q     <= '1;
         addr_held <= addr;
      end else if (busy) begin
         crc_q   <= crc_nxt;
         shreg_q <= shreg_q >> 1;
         cnt_q   <= cnt_q + 1'b1;
         if (last) busy <= 1'b0;
      end
   end

   // R8: the bit counter never runs past the last address bit
   p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> cnt_q <= CNT_LAST);

   // R8: the final bit ends the hash
   p_last_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> !busy);

   // R9: a start during a hash leaves the captured address untouched
   p_ignore_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(addr_held));

endmodule

// File: rtl/dafilt_decide.sv
module dafilt_decide #(
   parameter int unsigned ADDR_W    = 48,
   parameter int unsigned HASH_BITS = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      last,
   input  logic [HASH_BITS-1:0]      idx_next,
   input  logic [ADDR_W-1:0]         addr_held,
   input  logic [ADDR_W-1:0]         station,
   input  logic [(1<<HASH_BITS)-1:0] ind_tbl,
   input  logic [(1<<HASH_BITS)-1:0] grp_tbl,
   output logic                      done,
   output logic                      accept
);
   localparam int unsigned GRP_BIT = ADDR_W - 8;

   logic is_group;
   logic is_bcast;
   logic is_station;
   logic tbl_hit;
   logic verdict;

   assign is_group   = addr_held[GRP_BIT];
   assign is_bcast   = &addr_held;
   assign is_station = (addr_held == station);
   assign tbl_hit    = is_group ? grp_tbl[idx_next] : ind_tbl[idx_next];
   assign verdict    = is_bcast || is_station || tbl_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done   <= 1'b0;
         accept <= 1'b0;
      end else begin
         done <= last;
         if (last) accept <= verdict;
      end
   end

   // R8: done is a single-cycle strobe
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8: accept is held between verdicts
   p_accept_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !last |=> $stable(accept));

   // R6: broadcast is never rejected
   p_bcast_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (&addr_held)) |-> accept);

   // R7: empty group table rejects group traffic
   p_nogroup_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && addr_held[GRP_BIT] && grp_tbl == '0 && !(&addr_held)
       && addr_held != station) |-> !accept);

   // R5: station address is always kept
   p_station_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && addr_held == station) |-> accept);

endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter #(
   parameter int unsigned ADDR_BYTES = 6,
   parameter int unsigned REG_W      = 32,
   parameter int unsigned SEL_W      = 3,
   parameter int unsigned CRC_W      = 32,
   parameter int unsigned HASH_BITS  = 6,
   parameter logic [31:0] CRC_POLY   = 32'hEDB88320
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [SEL_W-1:0]         wr_sel,
   input  logic [REG_W-1:0]         wr_data,
   input  logic [SEL_W-1:0]         rd_sel,
   output logic [REG_W-1:0]         rd_data,
   input  logic                     start,
   input  logic [8*ADDR_BYTES-1:0]  addr_in,
   output logic                     done,
   output logic                     accept
);
   localparam int unsigned ADDR_W = 8 * ADDR_BYTES;
   localparam int unsigned TBL_W  = 2 * REG_W;

   // elaboration-time parameter checks
   if (ADDR_W != REG_W + REG_W / 2) begin : g_chk_addr
      $error("station address must fill one word and one half word");
   end
   if ((1 << HASH_BITS) != TBL_W) begin : g_chk_tbl
      $error("hash index range must cover exactly two table words");
   end
   if (HASH_BITS > CRC_W || CRC_W > 32) begin : g_chk_crc
      $error("hash index wider than the CRC or CRC wider than polynomial");
   end
   if (SEL_W < 3) begin : g_chk_sel
      $error("select field too narrow for six registers");
   end

   logic [ADDR_W-1:0]    station;
   logic [TBL_W-1:0]     ind_tbl;
   logic [TBL_W-1:0]     grp_tbl;
   logic                 busy;
   logic                 last;
   logic [HASH_BITS-1:0] idx_next;
   logic [ADDR_W-1:0]    addr_held;

   dafilt_regfile #(
      .REG_W  (REG_W),
      .SEL_W  (SEL_W),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .rd_sel  (rd_sel),
      .rd_data (rd_data),
      .station (station),
      .ind_tbl (ind_tbl),
      .grp_tbl (grp_tbl)
   );

   dafilt_crc_engine #(
      .ADDR_BYTES (ADDR_BYTES),
      .CRC_W      (CRC_W),
      .HASH_BITS  (HASH_BITS),
      .CRC_POLY   (CRC_POLY)
   ) u_crc (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .addr      (addr_in),
      .busy      (busy),
      .last      (last),
      .idx_next  (idx_next),
      .addr_held (addr_held)
   );

   dafilt_decide #(
      .ADDR_W    (ADDR_W),
      .HASH_BITS (HASH_BITS)
   ) u_decide (
      .clk       (clk),
      .rst_n     (rst_n),
      .last      (last),
      .idx_next  (idx_next),
      .addr_held (addr_held),
      .station   (station),
      .ind_tbl   (ind_tbl),
      .grp_tbl   (grp_tbl),
      .done      (done),
      .accept    (accept)
   );

   // R8: a verdict only follows a running hash
   p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));

   // R9: an idle start always begins a hash
   p_start_runs_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

endmodule

// File: tb/dst_addr_filter_tb_top.sv
module dst_addr_filter_tb_top;

   localparam logic [31:0] POLY = 32'hEDB88320;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_sel = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_sel = '0;
   logic [31:0] rd_data;
   logic        start = 1'b0;
   logic [47:0] addr_in = '0;
   logic        done;
   logic        accept;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit finished = 0;

   logic exp_q[$];
   int   cyc_q[$];
   string tag_q[$];

   logic [47:0] m_stn = '0;
   logic [63:0] m_ind = '0;
   logic [63:0] m_grp = '0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dst_addr_filter dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .rd_sel  (rd_sel),
      .rd_data (rd_data),
      .start   (start),
      .addr_in (addr_in),
      .done    (done),
      .accept  (accept)
   );

   function automatic logic [5:0] ref_idx(input logic [47:0] a);
      logic [31:0] c;
      logic [7:0]  by;
      c = '1;
      for (int b = 0; b < 6; b++) begin
         by = a[47 - 8*b -: 8];
         for (int j = 0; j < 8; j++) begin
            if (by[j] ^ c[0]) c = (c >> 1) ^ POLY;
            else              c = c >> 1;
         end
      end
      return c[31:26];
   endfunction

   function automatic logic ref_accept(input logic [47:0] a);
      logic [63:0] t;
      if (a == '1 || a == m_stn) return 1'b1;
      t = a[40] ? m_grp : m_ind;
      return t[ref_idx(a)];
   endfunction

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got 0x%0h exp 0x%0h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] sel, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      case (sel)
         3'd0: m_stn[47:16] = d;
         3'd1: m_stn[15:0]  = d[31:16];
         3'd2: m_ind[31:0]  = d;
         3'd3: m_ind[63:32] = d;
         3'd4: m_grp[31:0]  = d;
         3'd5: m_grp[63:32] = d;
         default: ;
      endcase
   endtask

   task automatic set_tbl(input bit grp, input logic [63:0] v);
      wr(grp ? 3'd4 : 3'd2, v[31:0]);
      wr(grp ? 3'd5 : 3'd3, v[63:32]);
   endtask

   task automatic rd_check(input string tag, input logic [2:0] sel, input logic [31:0] exp);
      @(negedge clk);
      rd_sel = sel;
      #1 check(tag, rd_data, exp);
   endtask

   // driver: pulse start, push expected verdict and cycle
   task automatic launch(input string tag, input logic [47:0] a, input logic exp);
      @(negedge clk);
      start = 1'b1; addr_in = a;
      @(negedge clk);
      start = 1'b0;
      exp_q.push_back(exp);
      cyc_q.push_back(cyc + 48);
      tag_q.push_back(tag);
   endtask

   task automatic run(input string tag, input logic [47:0] a, input logic exp);
      launch(tag, a, exp);
      wait (exp_q.size() == 0);
      @(negedge clk);
   endtask

   // monitor: compare every done against the scoreboard (R8 timing)
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R8/R9 unexpected done got 1 exp 0 at cycle %0d", cyc);
         end else begin
            logic e; int ec; string t;
            e = exp_q.pop_front(); ec = cyc_q.pop_front(); t = tag_q.pop_front();
            check({t, " R8 done cycle"}, cyc, ec);
            check(t, accept, e);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog got timeout exp completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [47:0] a;
      logic [5:0]  ix;
      bit seen_hi, seen_lo;
      seen_hi = 0; seen_lo = 0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 done", done, 0);
      check("R1 accept", accept, 0);
      rd_check("R1 reg0", 3'd0, 32'h0);
      rd_check("R1 reg1", 3'd1, 32'h0000_8808);
      rd_check("R1 reg5", 3'd5, 32'h0);

      // R10 readback
      wr(3'd1, 32'hABCD_1234);
      rd_check("R10 marker", 3'd1, 32'hABCD_8808);
      wr(3'd0, 32'h0200_5E11);
      rd_check("R10 reg0", 3'd0, 32'h0200_5E11);
      wr(3'd6, 32'hDEAD_BEEF);
      rd_check("R10 sel6", 3'd6, 32'h0);
      rd_check("R10 sel7", 3'd7, 32'h0);

      // R5 station match with empty tables, R3 other unicast rejected
      run("R5 station", 48'h0200_5E11_ABCD, 1'b1);
      run("R3 miss", 48'h0200_5E11_ABCE, ref_accept(48'h0200_5E11_ABCE));
      check("R3 model miss", ref_accept(48'h0200_5E11_ABCE), 0);

      // R2/R3 sweep: exact bit accepted, neighbour rejected
      for (int k = 0; k < 10; k++) begin
         a = 48'h0A1B_2C3D_4E00 + k * 48'h0001_0203_0507;
         a[40] = 1'b0;
         ix = ref_idx(a);
         if (ix >= 32) seen_hi = 1; else seen_lo = 1;
         set_tbl(0, 64'd1 << ix);
         run("R2 R3 hit", a, 1'b1);
         set_tbl(0, 64'd1 << (ix ^ 6'd1));
         run("R2 R3 neighbour", a, 1'b0);
      end
      // R3 make sure both words were used; force the missing half if needed
      for (int k = 0; k < 64 && !(seen_hi && seen_lo); k++) begin
         a = 48'h1234_5678_9A00 + k;
         a[40] = 1'b0;
         ix = ref_idx(a);
         if ((ix >= 32 && !seen_hi) || (ix < 32 && !seen_lo)) begin
            if (ix >= 32) seen_hi = 1; else seen_lo = 1;
            set_tbl(0, 64'd1 << ix);
            run("R3 half", a, 1'b1);
         end
      end
      check("R3 both halves covered", {31'd0, seen_hi && seen_lo}, 1);

      // R4/R7 group address with individual table full, group table empty
      set_tbl(0, '1);
      set_tbl(1, '0);
      a = 48'h0100_5E00_0001;
      run("R7 group rejected", a, 1'b0);
      set_tbl(1, 64'd1 << ref_idx(a));
      run("R4 group table hit", a, 1'b1);
      // R4 unicast ignores the group table
      set_tbl(1, '1);
      set_tbl(0, '0);
      run("R4 unicast uses individual", 48'h0A00_0000_0077, 1'b0);

      // R6 broadcast with empty tables
      set_tbl(1, '0);
      run("R6 broadcast", 48'hFFFF_FFFF_FFFF, 1'b1);

      // R9 start while busy is ignored
      set_tbl(0, 64'd1 << ref_idx(48'h0A11_2233_4455));
      launch("R9 first", 48'h0A11_2233_4455, 1'b1);
      repeat (10) @(negedge clk);
      start = 1'b1; addr_in = 48'h0A99_8877_6655;
      @(negedge clk);
      start = 1'b0;
      wait (exp_q.size() == 0);
      repeat (60) @(negedge clk);
      check("R9 no extra done", done, 0);

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule